// File: doc/BRIEF.md
# RGB to YCbCr Pixel Converter

This block turns a stream of RGB pixels, eight bits per channel, into luma (Y) and the two colour-difference components (Cb, Cr). It accepts one pixel in any clock cycle where the input valid is high and returns the three results, each eight bits and unsigned, a fixed three cycles later with a matching output valid. The pixel stream may have gaps: cycles with the input valid low carry no pixel and produce no result.

The weights are signed fractions below one in magnitude. Each is stored as its rounded magnitude in `FRAC_W` fraction bits, and its sign is applied by negating the product of two non-negative numbers. The three weighted terms and the chroma offset are summed at full width. Rounding happens once at the end, and the result is saturated to the 8-bit range. A wider `FRAC_W` trades multiplier area for accuracy.

Top module: `rgb2ycc_conv`

## Requirements
- R1: Each weight w is held as the integer magnitude q = floor(|w|·2^F + 1/2), where F = `FRAC_W` (default 14). A term with a negative weight contributes −(q·x), never q·(−x). In the sums below, "Σ" means the signed sum of the three terms.
- R2: Y = sat(floor((Σ + 2^(F−1)) / 2^F)), with weights +0.299 on red, +0.587 on green and +0.114 on blue.
- R3: Cb = sat(floor((Σ + 128·2^F + 2^(F−1)) / 2^F)), with weights −0.1687 on red, −0.3313 on green and +0.5 on blue.
- R4: Cr = sat(floor((Σ + 128·2^F + 2^(F−1)) / 2^F)), with weights +0.5 on red, −0.4187 on green and −0.0813 on blue.
- R5: Rounding adds half an output LSB and then takes the floor, so an exact half rounds upward. For example, red=0, green=0, blue=1 gives Cb = 129 (from 128.5), and blue=3 gives Cb = 130.
- R6: sat() clamps to 0..255. For example, red=255, green=0, blue=0 gives Cr = 255 (from 256 before clamping).
- R7: `out_vld` equals `in_vld` from three clock cycles earlier. The results for a pixel are on the outputs in the same cycle as its `out_vld`.
- R8: While `rst_n` is low, `out_vld` is low. Asserting `rst_n` discards every pixel in flight, and no result for such a pixel ever appears.
- R9: A cycle with `in_vld` low produces a cycle with `out_vld` low three cycles later, whatever the pixel inputs carry.
- R10: Every result is within one LSB of the real-valued formula clamped to 0..255.
- R11: While `out_vld` is low, `out_y`, `out_cb` and `out_cr` hold the last valid result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously to clk |
| in_vld | input | 1 | Pixel on in_r/in_g/in_b is valid this cycle |
| in_r | input | 8 | Red sample, unsigned |
| in_g | input | 8 | Green sample, unsigned |
| in_b | input | 8 | Blue sample, unsigned |
| out_vld | output | 1 | Results are valid this cycle |
| out_y | output | 8 | Luma result |
| out_cb | output | 8 | Blue colour-difference result |
| out_cr | output | 8 | Red colour-difference result |

## Verification
Every result is due exactly three rising edges after the edge that captured its pixel. The bench drives each pixel at a falling edge and pushes its expected result, or an empty slot for an idle cycle, onto a queue kept three entries deep. At every later falling edge it pops the oldest entry and compares it with all four outputs. When a reset is asserted, the bench replaces the queue with empty slots, because the block discards every pixel still in its pipeline.

// File: rtl/ycc_pkg.sv
package ycc_pkg;

  localparam int PIX_W  = 8;
  localparam int NUM_CH = 3;
  localparam int NUM_IN = 3;

  typedef enum logic [1:0] {
    CH_Y  = 2'd0,
    CH_CB = 2'd1,
    CH_CR = 2'd2
  } chan_e;

  // weight magnitude in units of 1e-4, by output channel and input (0=red,1=green,2=blue)
  function automatic int coef_e4(chan_e ch, int idx);
    int v;
    v = 0;
    case (ch)
      CH_Y:    v = (idx == 0) ? 2990 : (idx == 1) ? 5870 : 1140;
      CH_CB:   v = (idx == 0) ? 1687 : (idx == 1) ? 3313 : 5000;
      default: v = (idx == 0) ? 5000 : (idx == 1) ? 4187 : 813;
    endcase
    return v;
  endfunction

  function automatic bit coef_neg(chan_e ch, int idx);
    bit n;
    n = 1'b0;
    case (ch)
      CH_Y:    n = 1'b0;
      CH_CB:   n = (idx != 2);
      default: n = (idx != 0);
    endcase
    return n;
  endfunction

  // rounded magnitude with frac_w fraction bits
  function automatic longint qcoef(int num_e4, int frac_w);
    return (longint'(num_e4) * (longint'(1) << frac_w) + 64'sd5000) / 64'sd10000;
  endfunction

endpackage

// File: rtl/ycc_vld_pipe.sv
module ycc_vld_pipe #(
  parameter int DEPTH = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             vld_in,
  output logic [DEPTH-1:0] taps
);

  logic [DEPTH-1:0] taps_d;

  always_comb begin
    taps_d = {taps[DEPTH-2:0], vld_in};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) taps <= '0;
    else        taps <= taps_d;
  end

endmodule

// File: rtl/ycc_mac_lane.sv
module ycc_mac_lane
  import ycc_pkg::*;
#(
  parameter int    FRAC_W = 14,
  parameter chan_e CH     = CH_Y,
  localparam int   MAG_W  = FRAC_W,
  localparam int   PROD_W = PIX_W + MAG_W,
  localparam int   ACC_W  = PROD_W + 3
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           s1_en,
  input  logic                           s2_en,
  input  logic [NUM_IN-1:0][PIX_W-1:0]   px,
  output logic signed [ACC_W-1:0]        acc_q
);

  localparam logic signed [ACC_W-1:0] OFFSET =
    (CH == CH_Y) ? '0 : (ACC_W'(128) << FRAC_W);

  logic signed [ACC_W-1:0] term_d [NUM_IN];
  logic signed [ACC_W-1:0] term_q [NUM_IN];
  logic signed [ACC_W-1:0] acc_d;

  for (genvar i = 0; i < NUM_IN; i++) begin : g_term
    localparam logic [MAG_W-1:0] MAG = MAG_W'(qcoef(coef_e4(CH, i), FRAC_W));
    localparam bit               NEG = coef_neg(CH, i);
    logic [PROD_W-1:0] mag_prod;

    assign mag_prod = PROD_W'(MAG) * PROD_W'(px[i]);

    // the sign goes on after the unsigned product
    if (NEG) begin : g_neg
      assign term_d[i] = -$signed({3'b000, mag_prod});
    end else begin : g_pos
      assign term_d[i] = $signed({3'b000, mag_prod});
    end

    // R1: a nonzero sample times a negative weight lands negative in stage 1
    assert_term_sign_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (s1_en && px[i] != '0) |=> (term_q[i][ACC_W-1] == NEG));
  end

  // stage 1: products
  always_ff @(posedge clk) begin
    if (s1_en) begin
      for (int i = 0; i < NUM_IN; i++) term_q[i] <= term_d[i];
    end
  end

  // stage 2: sum plus offset
  always_comb begin
    acc_d = OFFSET;
    for (int i = 0; i < NUM_IN; i++) acc_d = acc_d + term_q[i];
  end

  always_ff @(posedge clk) begin
    if (s2_en) acc_q <= acc_d;
  end

  if (CH == CH_Y) begin : g_luma_chk
    // R2: luma weights are all positive, so the sum never goes negative
    assert_luma_nonneg_R2: assert property (@(posedge clk) disable iff (!rst_n)
      s2_en |=> !acc_q[ACC_W-1]);
  end

endmodule

// File: rtl/ycc_round_sat.sv
module ycc_round_sat
  import ycc_pkg::*;
#(
  parameter int  FRAC_W = 14,
  parameter int  ACC_W  = FRAC_W + PIX_W + 3
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    en,
  input  logic signed [ACC_W-1:0] acc,
  output logic [PIX_W-1:0]        res_q
);

  localparam logic signed [ACC_W:0]   HALF   = (ACC_W+1)'(1) << (FRAC_W - 1);
  localparam logic signed [ACC_W:0]   SAT_HI = (ACC_W+1)'(255);
  localparam logic signed [ACC_W-1:0] HI_THR = ACC_W'(511) << (FRAC_W - 1);
  localparam logic signed [ACC_W-1:0] LO_THR = -(ACC_W'(1) << (FRAC_W - 1));

  logic signed [ACC_W:0]  rnd;
  logic signed [ACC_W:0]  shr;
  logic [PIX_W-1:0]       res_d;

  always_comb begin
    rnd = {acc[ACC_W-1], acc} + HALF;
    shr = rnd >>> FRAC_W;
    if (shr[ACC_W])        res_d = '0;
    else if (shr > SAT_HI) res_d = '1;
    else                   res_d = shr[PIX_W-1:0];
  end

  // stage 3: rounded, clamped result
  always_ff @(posedge clk) begin
    if (en) res_q <= res_d;
  end

  // R6: a sum of at least 255.5 output LSBs saturates high
  assert_sat_high_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (en && acc >= HI_THR) |=> (res_q == 8'd255));

  // R6: a sum below minus half an output LSB saturates low
  assert_sat_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (en && acc < LO_THR) |=> (res_q == 8'd0));

  // R11: the result register moves only on a valid slot
  assert_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> $stable(res_q));

endmodule

// File: rtl/rgb2ycc_conv.sv
module rgb2ycc_conv
  import ycc_pkg::*;
#(
  parameter int FRAC_W = 14
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       in_vld,
  input  logic [7:0] in_r,
  input  logic [7:0] in_g,
  input  logic [7:0] in_b,
  output logic       out_vld,
  output logic [7:0] out_y,
  output logic [7:0] out_cb,
  output logic [7:0] out_cr
);

  localparam int STAGES = 3;
  localparam int ACC_W  = FRAC_W + PIX_W + 3;

  logic [STAGES-1:0]              vld_taps;
  logic [NUM_IN-1:0][PIX_W-1:0]   px;
  logic [NUM_CH-1:0][PIX_W-1:0]   ch_res;

  assign px = {in_b, in_g, in_r};

  ycc_vld_pipe #(.DEPTH(STAGES)) u_vld (
    .clk    (clk),
    .rst_n  (rst_n),
    .vld_in (in_vld),
    .taps   (vld_taps)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic signed [ACC_W-1:0] acc;

    ycc_mac_lane #(.FRAC_W(FRAC_W), .CH(chan_e'(c))) u_lane (
      .clk   (clk),
      .rst_n (rst_n),
      .s1_en (in_vld),
      .s2_en (vld_taps[0]),
      .px    (px),
      .acc_q (acc)
    );

    ycc_round_sat #(.FRAC_W(FRAC_W), .ACC_W(ACC_W)) u_sat (
      .clk   (clk),
      .rst_n (rst_n),
      .en    (vld_taps[1]),
      .acc   (acc),
      .res_q (ch_res[c])
    );
  end

  assign out_vld = vld_taps[STAGES-1];
  assign out_y   = ch_res[CH_Y];
  assign out_cb  = ch_res[CH_CB];
  assign out_cr  = ch_res[CH_CR];

  // cycles since reset, saturating, for the latency check
  logic [1:0] warm_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              warm_q <= '0;
    else if (warm_q != 2'd3) warm_q <= warm_q + 2'd1;
  end

  // R7: output valid is the input valid three cycles late
  assert_latency_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (warm_q == 2'd3) |-> (out_vld == $past(in_vld, 3)));

  // R8: no valid output while reset is held
  assert_reset_quiet_R8: assert property (@(posedge clk)
    !rst_n |-> !out_vld);

endmodule

// File: tb/sim_rgb2ycc_conv.sv
`timescale 1ns/1ps
module sim_rgb2ycc_conv;

  localparam int  FW     = 14;
  localparam real TCLK   = 8.0;
  localparam int  MAXCYC = 200000;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       in_vld;
  logic [7:0] in_r, in_g, in_b;
  logic       out_vld;
  logic [7:0] out_y, out_cb, out_cr;

  always #(TCLK/2) clk = ~clk;

  rgb2ycc_conv #(.FRAC_W(FW)) u0 (
    .clk(clk), .rst_n(rst_n), .in_vld(in_vld),
    .in_r(in_r), .in_g(in_g), .in_b(in_b),
    .out_vld(out_vld), .out_y(out_y), .out_cb(out_cb), .out_cr(out_cr)
  );

  typedef struct {
    bit  v;
    int  y, cb, cr;
    real fy, fcb, fcr;
    int  want_cb, want_cr;
    string tag;
  } slot_t;

  slot_t exp_q[$];
  int    n_run  = 0;
  int    n_fail = 0;
  bit    rst_req;
  bit    have_last = 1'b0;
  int    last_y, last_cb, last_cr;

  task automatic chk(bit ok, string req, int act, int expv);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d (t=%0t)", req, act, expv, $time);
    end
  endtask

  // integer model taken from the requirement formulas
  function automatic int exact_val(int ch, int r, int g, int b);
    int     num [3][3] = '{'{2990, 5870, 1140}, '{1687, 3313, 5000}, '{5000, 4187, 813}};
    bit     neg [3][3] = '{'{0, 0, 0}, '{1, 1, 0}, '{0, 1, 1}};
    int     x   [3];
    longint s, q;
    x[0] = r; x[1] = g; x[2] = b;
    s = 0;
    for (int i = 0; i < 3; i++) begin
      q = (longint'(num[ch][i]) * (longint'(1) << FW) + 5000) / 10000;
      if (neg[ch][i]) s = s - q * x[i];
      else            s = s + q * x[i];
    end
    if (ch != 0) s = s + (longint'(128) << FW);
    s = s + (longint'(1) << (FW - 1));
    s = s >>> FW;
    if (s < 0)   s = 0;
    if (s > 255) s = 255;
    return int'(s);
  endfunction

  function automatic real real_val(int ch, int r, int g, int b);
    real v;
    if (ch == 0)      v = 0.299*r + 0.587*g + 0.114*b;
    else if (ch == 1) v = -0.1687*r - 0.3313*g + 0.5*b + 128.0;
    else              v = 0.5*r - 0.4187*g - 0.0813*b + 128.0;
    if (v < 0.0)   v = 0.0;
    if (v > 255.0) v = 255.0;
    return v;
  endfunction

  function automatic bit near(int a, real f);
    real d;
    d = real'(a) - f;
    return (d <= 1.0) && (d >= -1.0);
  endfunction

  function automatic slot_t empty_slot();
    slot_t s;
    s.v = 0; s.y = 0; s.cb = 0; s.cr = 0;
    s.fy = 0.0; s.fcb = 0.0; s.fcr = 0.0;
    s.want_cb = -1; s.want_cr = -1; s.tag = "";
    return s;
  endfunction

  task automatic compare(slot_t e);
    if (e.v) begin
      chk(out_vld == 1'b1, "R7 valid due", out_vld, 1);
      chk(out_y  == e.y,  "R1/R2 luma",  out_y,  e.y);
      chk(out_cb == e.cb, "R1/R3 cb",    out_cb, e.cb);
      chk(out_cr == e.cr, "R1/R4 cr",    out_cr, e.cr);
      chk(near(out_y, e.fy) && near(out_cb, e.fcb) && near(out_cr, e.fcr),
          "R10 within one LSB", out_y, int'(e.fy));
      if (e.want_cb >= 0) chk(out_cb == e.want_cb, e.tag, out_cb, e.want_cb);
      if (e.want_cr >= 0) chk(out_cr == e.want_cr, e.tag, out_cr, e.want_cr);
      have_last = 1'b1;
      last_y = out_y; last_cb = out_cb; last_cr = out_cr;
    end else begin
      chk(out_vld == 1'b0, "R9 idle slot", out_vld, 0);
      if (have_last) begin
        chk(out_y == last_y && out_cb == last_cb && out_cr == last_cr,
            "R11 hold", out_y, last_y);
      end
    end
  endtask

  // one cycle: check the slot due now, then drive the next pixel
  task automatic step(bit v, int r, int g, int b, int wcb = -1, int wcr = -1, string tag = "");
    slot_t e;
    @(negedge clk);
    compare(exp_q.pop_front());
    if (rst_n && !rst_req) begin
      rst_n = 1'b0;
      #0.5;
      chk(out_vld == 1'b0, "R8 reset clears", out_vld, 0);
      exp_q.delete();
      exp_q.push_back(empty_slot());
      exp_q.push_back(empty_slot());
    end else begin
      rst_n = rst_req;
    end
    in_vld = v; in_r = 8'(r); in_g = 8'(g); in_b = 8'(b);
    e = empty_slot();
    e.v = v && rst_n;
    if (e.v) begin
      e.y  = exact_val(0, r, g, b);  e.fy  = real_val(0, r, g, b);
      e.cb = exact_val(1, r, g, b);  e.fcb = real_val(1, r, g, b);
      e.cr = exact_val(2, r, g, b);  e.fcr = real_val(2, r, g, b);
      e.want_cb = wcb; e.want_cr = wcr; e.tag = tag;
    end
    exp_q.push_back(e);
  endtask

  initial begin
    repeat (MAXCYC) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", MAXCYC, 0);
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; rst_req = 1'b0;
    in_vld = 1'b0; in_r = '0; in_g = '0; in_b = '0;
    for (int i = 0; i < 3; i++) exp_q.push_back(empty_slot());
    #1;
    chk(out_vld == 1'b0, "R8 reset state", out_vld, 0);
    for (int i = 0; i < 4; i++) step(1, 9, 9, 9);   // valid ignored under reset
    rst_req = 1'b1;
    for (int i = 0; i < 3; i++) step(0, 0, 0, 0);

    // directed corners
    step(1, 0, 0, 1, 129, -1, "R5 half rounds up");
    step(1, 0, 0, 3, 130, -1, "R5 half rounds up");
    step(1, 255, 0, 0, -1, 255, "R6 clamp high");
    step(1, 0, 0, 0, 128, 128, "R3 R4 black");
    step(1, 255, 255, 255);
    step(1, 0, 255, 0);
    step(1, 0, 0, 255);
    step(1, 255, 255, 0);
    step(1, 0, 255, 255);
    step(0, 77, 200, 13);                        // invalid pixel, no result
    step(0, 255, 255, 255);
    step(1, 128, 64, 32);
    for (int i = 0; i < 5; i++) step(0, i * 40, 3, 250);

    // back-to-back random pixels
    for (int i = 0; i < 800; i++) step(1, $urandom_range(255), $urandom_range(255), $urandom_range(255));

    // random gaps
    for (int i = 0; i < 1500; i++)
      step($urandom_range(3) != 0, $urandom_range(255), $urandom_range(255), $urandom_range(255));

    // reset with pixels in flight
    for (int i = 0; i < 3; i++) step(1, 200, 10, 90);
    rst_req = 1'b0;
    step(1, 1, 2, 3);
    step(1, 4, 5, 6);
    rst_req = 1'b1;
    for (int i = 0; i < 50; i++) step(1, $urandom_range(255), $urandom_range(255), $urandom_range(255));
    for (int i = 0; i < 4; i++) step(0, 0, 0, 0);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule